// File: doc/BRIEF.md
# Key Sequence Register Unlock Guard

This block stands in front of a 32-bit control register and keeps software from changing it by accident. After reset the register ignores writes. Software opens it by writing two fixed 32-bit keys, one after the other, to a separate key register. Once the register is open, software may write it freely. Setting the top bit of the register closes it again, and the same two keys open it once more.

A wrong value written to the key register at any point raises a bus error. It also puts the guard into a frozen state. The frozen state leaves the control register read-only until the next reset, whatever keys arrive afterwards. An external busy input marks a period in which an operation is running. While busy is high, writes to the control register are held with ready low until busy falls, and then they complete. Reads are never held. The register bus is a single-beat request interface: a request that sees ready high completes at that clock edge, and error is valid in the same cycle.

Top module: `key_unlock_guard`

## Requirements
- R1: After reset the control register reads 0x80000000. Bit 31 is the lock indicator, and it reads 1 whenever writes are refused. The `ctrl_value` output shows the same value.
- R2: A write to the control register (word address 0) while it is not unlocked completes with `bus_err`=1 and leaves the register unchanged. Such a write made between the two keys does not break the key sequence.
- R3: Writing 0x45670123 and then 0xCDEF89AB to the key register (word address 1) unlocks the control register. Bit 31 then reads 0, and writes to bits 30:0 take effect with `bus_err`=0.
- R4: If the first key write is not 0x45670123, it returns `bus_err`=1 and freezes the guard. Later correct keys also return errors and do not unlock.
- R5: If the second key write is not 0xCDEF89AB, it returns `bus_err`=1 and freezes the guard in the same way.
- R6: A key register write while the guard is already unlocked returns `bus_err`=1, relocks the register and freezes the guard.
- R7: A control write with bit 31 set, made while unlocked, stores bits 30:0 and relocks. The full two-key sequence then unlocks the register again.
- R8: While `bus_busy`=1, a control register write is held with `bus_ready`=0 until busy clears, and then it completes. Reads are not held.
- R9: Reads never return an error. The key register and unmapped addresses read 0. Writes to unmapped addresses complete without error and change nothing.
- R10: The frozen state is left only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Transfer request, held until accepted |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (4) | Word address: 0 control, 1 key |
| bus_wdata | input | 32 | Write data |
| bus_busy | input | 1 | Operation in progress; holds control writes |
| bus_rdata | output | 32 | Read data, valid while request is accepted |
| bus_ready | output | 1 | Request accepted this cycle |
| bus_err | output | 1 | Error response, valid with ready |
| ctrl_value | output | 32 | Current control register view (bit 31 = locked) |

## Verification
The bench targets the sticky lockout from every entry point: a bad first key, a bad second key, and a key write after unlocking. Each of these is followed by the correct keys. A design that only returned to the locked state would let those keys reopen the register, and the reads that follow would show bit 31 clear. A control write placed between the two keys shows whether such a write wrongly resets the sequence. A relock followed by a fresh unlock shows whether the software relock was mistaken for a permanent freeze. The busy test counts cycles with ready low and then confirms that the held write landed. A design that dropped the write, or one that also held reads, would report a wrong read value or a missing response.

// File: rtl/kug_pkg.sv
package kug_pkg;
  localparam int unsigned BUS_DW = 32;
  localparam logic [BUS_DW-1:0] KEY_FIRST  = 32'h4567_0123;
  localparam logic [BUS_DW-1:0] KEY_SECOND = 32'hCDEF_89AB;

  typedef enum logic [1:0] {
    ST_LOCKED   = 2'd0,
    ST_KEY1_OK  = 2'd1,
    ST_UNLOCKED = 2'd2,
    ST_FROZEN   = 2'd3
  } kug_state_e;

  // Next state of the guard after a key register write.
  function automatic kug_state_e key_step(kug_state_e cur, logic [BUS_DW-1:0] wd);
    kug_state_e nxt;
    case (cur)
      ST_LOCKED:  nxt = (wd == KEY_FIRST)  ? ST_KEY1_OK  : ST_FROZEN;
      ST_KEY1_OK: nxt = (wd == KEY_SECOND) ? ST_UNLOCKED : ST_FROZEN;
      default:    nxt = ST_FROZEN;
    endcase
    return nxt;
  endfunction

  // A key write is wrong whenever it leads into the frozen state.
  function automatic logic key_is_bad(kug_state_e cur, logic [BUS_DW-1:0] wd);
    return key_step(cur, wd) == ST_FROZEN;
  endfunction
endpackage

// File: rtl/kug_decode.sv
module kug_decode #(
  parameter int unsigned AW        = 4,
  parameter int unsigned CTRL_ADDR = 0,
  parameter int unsigned KEY_ADDR  = 1
) (
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic          busy,
  output logic          hit_ctrl,
  output logic          hit_key,
  output logic          stall,
  output logic          ready,
  output logic          wr_ctrl_fire,
  output logic          wr_key_fire,
  output logic          rd_fire
);
  localparam logic [AW-1:0] CTRL_A = AW'(CTRL_ADDR);
  localparam logic [AW-1:0] KEY_A  = AW'(KEY_ADDR);

  always_comb begin
    hit_ctrl     = (addr == CTRL_A);
    hit_key      = (addr == KEY_A);
    stall        = req & we & hit_ctrl & busy;
    ready        = req & ~stall;
    wr_ctrl_fire = ready & we & hit_ctrl;
    wr_key_fire  = ready & we & hit_key;
    rd_fire      = ready & ~we;
  end
endmodule

// File: rtl/kug_lock_fsm.sv
module kug_lock_fsm
  import kug_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_fire,
  input  logic [BUS_DW-1:0] key_data,
  input  logic              relock_req,
  output kug_state_e        state_o,
  output logic              unlocked_o,
  output logic              key_err_o
);
  kug_state_e state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_LOCKED;
    end else if (key_fire) begin
      state_q <= key_step(state_q, key_data);
    end else if (relock_req && state_q == ST_UNLOCKED) begin
      state_q <= ST_LOCKED;
    end
  end

  always_comb begin
    state_o    = state_q;
    unlocked_o = (state_q == ST_UNLOCKED);
    key_err_o  = key_fire & key_is_bad(state_q, key_data);
  end

  p_frozen_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_FROZEN |=> state_q == ST_FROZEN);

  p_unlock_after_key1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked_o) |-> $past(state_q) == ST_KEY1_OK);

  p_key_when_open_freezes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (key_fire && state_q == ST_UNLOCKED) |=> state_q == ST_FROZEN);
endmodule

// File: rtl/kug_ctrl_reg.sv
module kug_ctrl_reg
  import kug_pkg::*;
#(
  parameter int unsigned LOCK_BIT = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BUS_DW-1:0] wdata,
  input  logic              locked,
  output logic [BUS_DW-1:0] view_o
);
  localparam logic [BUS_DW-1:0] LOCK_MASK = BUS_DW'(1) << LOCK_BIT;

  logic [BUS_DW-1:0] data_q;

  function automatic logic [BUS_DW-1:0] make_view(logic [BUS_DW-1:0] d, logic lk);
    return (d & ~LOCK_MASK) | (lk ? LOCK_MASK : '0);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     data_q <= '0;
    else if (wr_en) data_q <= wdata & ~LOCK_MASK;
  end

  assign view_o = make_view(data_q, locked);

  p_lock_bit_never_stored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (data_q & LOCK_MASK) == '0);
endmodule

// File: rtl/key_unlock_guard.sv
module key_unlock_guard
  import kug_pkg::*;
#(
  parameter int unsigned AW        = 4,
  parameter int unsigned CTRL_ADDR = 0,
  parameter int unsigned KEY_ADDR  = 1,
  parameter int unsigned LOCK_BIT  = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  input  logic              bus_busy,
  output logic [BUS_DW-1:0] bus_rdata,
  output logic              bus_ready,
  output logic              bus_err,
  output logic [BUS_DW-1:0] ctrl_value
);
  logic       hit_ctrl, hit_key, stall;
  logic       wr_ctrl_fire, wr_key_fire, rd_fire;
  logic       unlocked, key_err, relock_req, ctrl_we, ctrl_reject;
  kug_state_e state;
  logic [BUS_DW-1:0] view;

  kug_decode #(.AW(AW), .CTRL_ADDR(CTRL_ADDR), .KEY_ADDR(KEY_ADDR)) u_dec (
    .req(bus_req), .we(bus_we), .addr(bus_addr), .busy(bus_busy),
    .hit_ctrl(hit_ctrl), .hit_key(hit_key), .stall(stall), .ready(bus_ready),
    .wr_ctrl_fire(wr_ctrl_fire), .wr_key_fire(wr_key_fire), .rd_fire(rd_fire)
  );

  assign ctrl_we     = wr_ctrl_fire & unlocked;
  assign ctrl_reject = wr_ctrl_fire & ~unlocked;
  assign relock_req  = ctrl_we & bus_wdata[LOCK_BIT];

  kug_lock_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .key_fire(wr_key_fire), .key_data(bus_wdata),
    .relock_req(relock_req), .state_o(state), .unlocked_o(unlocked),
    .key_err_o(key_err)
  );

  kug_ctrl_reg #(.LOCK_BIT(LOCK_BIT)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(ctrl_we), .wdata(bus_wdata),
    .locked(~unlocked), .view_o(view)
  );

  always_comb begin
    bus_err    = key_err | ctrl_reject;
    bus_rdata  = (rd_fire && hit_ctrl) ? view : '0;
    ctrl_value = view;
  end

  p_busy_holds_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && hit_ctrl && bus_busy) |-> !bus_ready);

  p_rejected_write_no_effect_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_reject |=> $stable(ctrl_value));

  p_err_only_with_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> bus_ready && bus_we);

  p_frozen_reads_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_FROZEN |-> ctrl_value[LOCK_BIT]);
endmodule

// File: tb/tb_key_unlock_guard.sv
module tb_key_unlock_guard;
  localparam logic [31:0] K1 = 32'h4567_0123;
  localparam logic [31:0] K2 = 32'hCDEF_89AB;
  localparam logic [3:0]  A_CTRL = 4'd0;
  localparam logic [3:0]  A_KEY  = 4'd1;
  localparam logic [3:0]  A_NONE = 4'd9;

  logic clk = 0, rst_n = 0;
  logic bus_req = 0, bus_we = 0, bus_busy = 0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, ctrl_value;
  logic bus_ready, bus_err;

  int checks = 0, errors = 0, cycles = 0;
  logic accepted = 0;

  logic        q_err[$];
  logic        q_chk[$];
  logic [31:0] q_rd[$];
  string       q_tag[$];

  always #4 clk = ~clk;

  key_unlock_guard dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_busy(bus_busy),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready), .bus_err(bus_err),
    .ctrl_value(ctrl_value)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected response per accepted transfer.
  always @(negedge clk) begin
    if (rst_n && bus_req && bus_ready) begin
      if (q_err.size() == 0) begin
        chk(1'b0, "unexpected response", 32'(bus_err), 32'h0);
      end else begin
        logic e; logic c; logic [31:0] r; string t;
        e = q_err.pop_front(); c = q_chk.pop_front();
        r = q_rd.pop_front();  t = q_tag.pop_front();
        chk(bus_err == e, {t, " err"}, 32'(bus_err), 32'(e));
        if (c) chk(bus_rdata == r, {t, " rdata"}, bus_rdata, r);
      end
      accepted = 1;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic launch(input logic we, input logic [3:0] a, input logic [31:0] wd,
                        input logic ee, input logic c, input logic [31:0] er, input string tag);
    q_err.push_back(ee); q_chk.push_back(c); q_rd.push_back(er); q_tag.push_back(tag);
    @(posedge clk); #1;
    bus_req = 1; bus_we = we; bus_addr = a; bus_wdata = wd;
  endtask

  task automatic finish_xfer();
    forever begin
      @(posedge clk);
      if (accepted) break;
    end
    accepted = 0;
    #1 bus_req = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] wd, input logic ee, input string tag);
    launch(1'b1, a, wd, ee, 1'b0, '0, tag);
    finish_xfer();
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] er, input string tag);
    launch(1'b0, a, '0, 1'b0, 1'b1, er, tag);
    finish_xfer();
  endtask

  task automatic do_reset();
    @(posedge clk); #1 rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
  endtask

  initial begin
    do_reset();
    @(negedge clk);
    chk(ctrl_value == 32'h8000_0000, "R1 reset view", ctrl_value, 32'h8000_0000);
    rd(A_CTRL, 32'h8000_0000, "R1 reset read");
    rd(A_KEY, 32'h0, "R9 key reads zero");
    wr(A_NONE, 32'hFFFF_FFFF, 1'b0, "R9 unmapped write");
    rd(A_NONE, 32'h0, "R9 unmapped read");

    wr(A_CTRL, 32'h0000_0012, 1'b1, "R2 locked write err");
    rd(A_CTRL, 32'h8000_0000, "R2 locked write ignored");

    wr(A_KEY, K1, 1'b0, "R3 key1");
    wr(A_KEY, K2, 1'b0, "R3 key2");
    rd(A_CTRL, 32'h0, "R3 unlocked view");
    wr(A_CTRL, 32'h0000_00A5, 1'b0, "R3 open write");
    rd(A_CTRL, 32'h0000_00A5, "R3 open write landed");

    wr(A_CTRL, 32'h8000_005A, 1'b0, "R7 relock write");
    rd(A_CTRL, 32'h8000_005A, "R7 relocked view");
    wr(A_CTRL, 32'h0000_0001, 1'b1, "R7 write after relock err");
    rd(A_CTRL, 32'h8000_005A, "R7 write after relock ignored");
    wr(A_KEY, K1, 1'b0, "R7 rekey1");
    wr(A_KEY, K2, 1'b0, "R7 rekey2");
    rd(A_CTRL, 32'h0000_005A, "R7 reopened");

    // R8: stall while busy
    bus_busy = 1;
    launch(1'b1, A_CTRL, 32'h0000_0033, 1'b0, 1'b0, '0, "R8 held write");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(bus_ready == 1'b0, "R8 ready low while busy", 32'(bus_ready), 32'h0);
    end
    @(posedge clk); #1 bus_busy = 0;
    finish_xfer();
    rd(A_CTRL, 32'h0000_0033, "R8 held write landed");
    bus_busy = 1;
    rd(A_CTRL, 32'h0000_0033, "R8 read not held");
    bus_busy = 0;

    wr(A_KEY, K1, 1'b1, "R6 key while open err");
    rd(A_CTRL, 32'h8000_0033, "R6 relocked");
    wr(A_KEY, K1, 1'b1, "R10 frozen key1");
    wr(A_KEY, K2, 1'b1, "R10 frozen key2");
    rd(A_CTRL, 32'h8000_0033, "R10 still frozen");

    do_reset();
    wr(A_KEY, 32'hDEAD_BEEF, 1'b1, "R4 bad first key");
    wr(A_KEY, K1, 1'b1, "R4 key1 after freeze");
    wr(A_KEY, K2, 1'b1, "R4 key2 after freeze");
    rd(A_CTRL, 32'h8000_0000, "R4 remains locked");

    do_reset();
    wr(A_KEY, K1, 1'b0, "R5 key1");
    wr(A_KEY, K1, 1'b1, "R5 bad second key");
    wr(A_KEY, K1, 1'b1, "R5 key1 after freeze");
    wr(A_KEY, K2, 1'b1, "R5 key2 after freeze");
    rd(A_CTRL, 32'h8000_0000, "R5 remains locked");

    do_reset();
    rd(A_CTRL, 32'h8000_0000, "R10 reset clears freeze");
    wr(A_KEY, K1, 1'b0, "R2 key1");
    wr(A_CTRL, 32'h0000_0077, 1'b1, "R2 write between keys err");
    wr(A_KEY, K2, 1'b0, "R2 sequence kept");
    rd(A_CTRL, 32'h0000_0000, "R2 unlocked after interleave");

    repeat (2) @(posedge clk);
    chk(q_err.size() == 0, "queue drained", 32'(q_err.size()), 32'h0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule